// File: doc/BRIEF.md
# Chained Operand Address Former

This block turns a 32-bit command word into an operand value, or into the address of one. It combines a 15-bit base field, an index register picked by a 6-bit index field, and a persistent operand assembly register (OA) that carries over from one command word to the next. A 2-bit mode field selects one of four forms. The base field either adds in directly or is first replaced by the memory word it points to. The summed value either becomes the operand or is used once more as a memory address.

A command word whose preparation flag is set leaves its result in OA, where the next word adds to it. A word without the flag ends the chain and clears OA. A chain of any length can therefore stack extra indexes and extra indirection onto one operand. A start-of-chain input makes the word being accepted see OA as zero. Memory is reached through a request/acknowledge read port of any latency. Index registers are reached through a combinational read port.

Top module: `operand_chain_unit`

## Requirements
- R1: The command word has the preparation flag at bit 31, a spare flag at bit 30, opcode at 29:23, mode at 22:21, index at 20:15 and base at 14:0. Neither the spare flag nor the opcode affects the operand, the memory reads or OA.
- R2: Mode 0 gives operand = OA + base + IDX[index], a 32-bit sum with the base zero-extended.
- R3: Mode 1 gives operand = OA + MEM[base] + IDX[index].
- R4: Mode 2 gives operand = MEM[(OA + base + IDX[index]) mod 2^15].
- R5: Mode 3 gives operand = MEM[(OA + MEM[base] + IDX[index]) mod 2^15].
- R6: An index field of 0 adds zero, whatever the index port returns for select 0. The values 1 to 63 add the index register returned for that select.
- R7: When chain_start is high with an accepted word, that word uses zero in place of OA.
- R8: When a word with the preparation flag completes, OA takes its operand. When a word without the flag completes, OA becomes zero.
- R9: done is a one-cycle pulse that comes only after every memory read for the word has been acknowledged. A read request holds its address until it is acknowledged. With an accept at edge E0, done is high in the cycle after edge E0 + 2 + sum of read durations. Each read lasts from the edge that raises mem_req to the edge that samples mem_ack, inclusive.
- R10: cmd_valid is ignored from the accept until the cycle after done. A word presented during that time is neither processed nor queued.
- R11: After reset, done and mem_req are low and OA is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command word present; accepted when the block is idle |
| cmd_word | input | 32 | Command word |
| chain_start | input | 1 | Treat OA as zero for this word |
| idx_sel | output | 6 | Index register select |
| idx_data | input | 32 | Contents of the selected index register (combinational) |
| mem_req | output | 1 | Memory read request, held until acknowledged |
| mem_addr | output | 15 | Memory read address |
| mem_ack | input | 1 | Read acknowledge; mem_rdata valid with it |
| mem_rdata | input | 32 | Memory read data |
| operand | output | 32 | Formed operand, valid while done is high |
| done | output | 1 | One-cycle completion pulse |

## Verification
Mode 0 makes no reads, and its done is due two edges after the accept edge. Each memory read adds the memory model's latency plus one cycle, so modes 1 and 2 add one read and mode 3 adds two. For every word the bench fixes the model's latency, works out the edge on which done is due, and counts negedge samples from the accept. It then checks that done first appears on exactly that sample, with the expected operand, and that it is low on the next sample. Stray words presented while busy must leave both the result and the following idle cycles unchanged.

// File: rtl/ocu_pkg.sv
`timescale 1ns/1ps
package ocu_pkg;
  localparam int BASE_W = 15;
  localparam int IDX_W  = 6;
  localparam int MODE_W = 2;
  localparam int OPC_W  = 7;
  localparam int CMD_W  = 2 + OPC_W + MODE_W + IDX_W + BASE_W;

  typedef struct packed {
    logic              prep;
    logic              spare;
    logic [OPC_W-1:0]  opc;
    logic [MODE_W-1:0] mode;
    logic [IDX_W-1:0]  idx;
    logic [BASE_W-1:0] base;
  } cmd_t;

  typedef enum logic [2:0] {
    S_IDLE, S_LOOK, S_RDA, S_ADD, S_RDX, S_FIN
  } state_t;

  // mode bit 0: base term is fetched from memory
  function automatic logic fetch_base(input logic [MODE_W-1:0] m);
    return m[0];
  endfunction

  // mode bit 1: the sum is used as an address once more
  function automatic logic indirect(input logic [MODE_W-1:0] m);
    return m[1];
  endfunction

  function automatic logic [1:0] read_count(input logic [MODE_W-1:0] m);
    return {1'b0, m[0]} + {1'b0, m[1]};
  endfunction
endpackage

// File: rtl/ocu_ctrl.sv
`timescale 1ns/1ps
module ocu_ctrl
  import ocu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [MODE_W-1:0] mode,
  input  logic              mem_ack,
  output state_t            state,
  output logic              ev_accept,
  output logic              ev_base_ack,
  output logic              ev_ind_ack,
  output logic              ev_done
);
  state_t     nxt;
  logic [1:0] rd_cnt;

  assign ev_accept   = (state == S_IDLE) && cmd_valid;
  assign ev_base_ack = (state == S_RDA) && mem_ack;
  assign ev_ind_ack  = (state == S_RDX) && mem_ack;
  assign ev_done     = (state == S_FIN);

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE: if (cmd_valid) nxt = S_LOOK;
      S_LOOK: nxt = fetch_base(mode) ? S_RDA : S_ADD;
      S_RDA:  if (mem_ack) nxt = S_ADD;
      S_ADD:  nxt = indirect(mode) ? S_RDX : S_FIN;
      S_RDX:  if (mem_ack) nxt = S_FIN;
      S_FIN:  nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         rd_cnt <= '0;
    else if (ev_accept)                 rd_cnt <= '0;
    else if (ev_base_ack || ev_ind_ack) rd_cnt <= rd_cnt + 2'd1;
  end

  // R9: done lasts one cycle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> !ev_done);
  // R9: every read of the word acknowledged before done
  a_r9_reads_complete: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |-> (rd_cnt == read_count(mode)));
  // R10: a busy block never starts a new word
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE) |=> (state != S_LOOK));
endmodule

// File: rtl/ocu_datapath.sv
`timescale 1ns/1ps
module ocu_datapath
  import ocu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  state_t            state,
  input  logic              ev_accept,
  input  logic              ev_base_ack,
  input  logic              ev_ind_ack,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic              chain_start,
  input  logic [DW-1:0]     oa_val,
  input  logic [DW-1:0]     idx_data,
  input  logic              mem_ack,
  input  logic [DW-1:0]     mem_rdata,
  output cmd_t              cmd_q,
  output logic [IDX_W-1:0]  idx_sel,
  output logic              mem_req,
  output logic [BASE_W-1:0] mem_addr,
  output logic [DW-1:0]     operand
);
  localparam int PAD_W = DW - BASE_W;

  logic [DW-1:0] oa_use_q;
  logic [DW-1:0] ival_q;
  logic [DW-1:0] term_q;
  logic [DW-1:0] x_q;

  function automatic logic [DW-1:0] form_sum(input logic [DW-1:0] oa,
                                             input logic [DW-1:0] term,
                                             input logic [DW-1:0] ival);
    return oa + term + ival;
  endfunction

  assign idx_sel  = cmd_q.idx;
  assign mem_req  = (state == S_RDA) || (state == S_RDX);
  assign mem_addr = (state == S_RDX) ? x_q[BASE_W-1:0] : cmd_q.base;
  assign operand  = x_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      oa_use_q <= '0;
      ival_q   <= '0;
      term_q   <= '0;
      x_q      <= '0;
    end else begin
      if (ev_accept) begin
        cmd_q    <= cmd_t'(cmd_word);
        oa_use_q <= chain_start ? '0 : oa_val;
      end
      if (state == S_LOOK) begin
        ival_q <= (cmd_q.idx == '0) ? '0 : idx_data;
        term_q <= {{PAD_W{1'b0}}, cmd_q.base};
      end
      if (ev_base_ack) term_q <= mem_rdata;
      if (state == S_ADD) x_q <= form_sum(oa_use_q, term_q, ival_q);
      if (ev_ind_ack) x_q <= mem_rdata;
    end
  end

  // R9: request and address held until acknowledged
  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
  // R7: chain start zeroes the assembly term
  a_r7_chain_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && chain_start) |=> (oa_use_q == '0));
  // R6: index select 0 contributes nothing
  a_r6_zero_index: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_LOOK) && (cmd_q.idx == '0)) |=> (ival_q == '0));
  // R10, R1: the latched word stays put while it is worked on
  a_r10_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
    ((state != S_IDLE) && (state != S_LOOK)) |-> $stable(cmd_q));
endmodule

// File: rtl/ocu_asm_reg.sv
`timescale 1ns/1ps
module ocu_asm_reg #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_done,
  input  logic          prep,
  input  logic [DW-1:0] x,
  output logic [DW-1:0] oa_val
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       oa_val <= '0;
    else if (ev_done) oa_val <= prep ? x : '0;
  end

  // R8: a preparation word leaves its result
  a_r8_keep_prep: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_done && prep) |=> (oa_val == $past(x)));
  // R8: a plain word ends the chain
  a_r8_clear_plain: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_done && !prep) |=> (oa_val == '0));
  // R8: nothing else touches OA
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_done |=> $stable(oa_val));
endmodule

// File: rtl/operand_chain_unit.sv
`timescale 1ns/1ps
module operand_chain_unit
  import ocu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic              chain_start,
  output logic [IDX_W-1:0]  idx_sel,
  input  logic [DW-1:0]     idx_data,
  output logic              mem_req,
  output logic [BASE_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [DW-1:0]     mem_rdata,
  output logic [DW-1:0]     operand,
  output logic              done
);
  state_t        state;
  cmd_t          cmd_q;
  logic          ev_accept, ev_base_ack, ev_ind_ack, ev_done;
  logic [DW-1:0] oa_val;

  ocu_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .mode(cmd_q.mode),
    .mem_ack(mem_ack), .state(state), .ev_accept(ev_accept),
    .ev_base_ack(ev_base_ack), .ev_ind_ack(ev_ind_ack), .ev_done(ev_done)
  );

  ocu_datapath #(.DW(DW)) i_dp (
    .clk(clk), .rst_n(rst_n), .state(state), .ev_accept(ev_accept),
    .ev_base_ack(ev_base_ack), .ev_ind_ack(ev_ind_ack),
    .cmd_word(cmd_word), .chain_start(chain_start), .oa_val(oa_val),
    .idx_data(idx_data), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .cmd_q(cmd_q), .idx_sel(idx_sel), .mem_req(mem_req),
    .mem_addr(mem_addr), .operand(operand)
  );

  ocu_asm_reg #(.DW(DW)) i_oa (
    .clk(clk), .rst_n(rst_n), .ev_done(ev_done), .prep(cmd_q.prep),
    .x(operand), .oa_val(oa_val)
  );

  assign done = ev_done;

  // R11: quiet outputs right after reset
  a_r11_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> (!done && !mem_req));
endmodule

// File: tb/test_operand_chain_unit.sv
`timescale 1ns/1ps
module test_operand_chain_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [31:0] cmd_word = '0;
  logic        chain_start = 1'b0;
  logic [5:0]  idx_sel;
  logic [31:0] idx_data;
  logic        mem_req;
  logic [14:0] mem_addr;
  logic        mem_ack;
  logic [31:0] mem_rdata;
  logic [31:0] operand;
  logic        done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int mem_lat = 1;
  logic [31:0] ifile [64];
  logic [31:0] oa_m = '0;

  always #2.5 clk = ~clk;

  operand_chain_unit i_operand_chain_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .chain_start(chain_start), .idx_sel(idx_sel), .idx_data(idx_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .operand(operand), .done(done)
  );

  function automatic logic [31:0] memv(input logic [14:0] a);
    return ({a, 17'h0} ^ ({17'h0, a} * 32'h9E37_79B9)) ^ 32'hC3A5_0F1E;
  endfunction

  // index register file, combinational read
  assign idx_data = ifile[idx_sel];

  // memory model: ack after mem_lat sampled request cycles
  logic       ack_q = 1'b0;
  logic [31:0] rd_q = '0;
  int         wcnt = 0;
  assign mem_ack   = ack_q;
  assign mem_rdata = rd_q;
  always @(posedge clk) begin
    if (ack_q) begin
      ack_q <= 1'b0;
      wcnt  <= 0;
    end else if (mem_req) begin
      if (wcnt + 1 >= mem_lat) begin
        ack_q <= 1'b1;
        rd_q  <= memv(mem_addr);
      end else begin
        wcnt <= wcnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // issue one word, check value, timing and OA model
  task automatic run_cmd(input bit prep, input bit spare, input logic [6:0] opc,
                         input logic [1:0] mode, input logic [5:0] idx,
                         input logic [14:0] base, input bit chain,
                         input int lat, input bit stray, input string req);
    logic [31:0] oa_in, iv, term, s, x;
    int nreads, due, seen;
    oa_in  = chain ? 32'h0 : oa_m;
    iv     = (idx == 6'd0) ? 32'h0 : ifile[idx];
    term   = mode[0] ? memv(base) : {17'h0, base};
    s      = oa_in + term + iv;
    x      = mode[1] ? memv(s[14:0]) : s;
    nreads = int'(mode[0]) + int'(mode[1]);
    due    = 2 + nreads * (lat + 1);
    mem_lat = lat;
    @(negedge clk);
    cmd_valid   = 1'b1;
    cmd_word    = {prep, spare, opc, mode, idx, base};
    chain_start = chain;
    @(posedge clk);
    seen = -1;
    for (int cyc = 0; cyc < 300; cyc++) begin
      @(negedge clk);
      if (cyc == 0) begin
        cmd_valid = stray;
        cmd_word  = $urandom;
        chain_start = stray;
      end else begin
        cmd_valid = 1'b0;
      end
      if (done) begin
        seen = cyc;
        break;
      end
    end
    chk(seen == due, "R9 latency", seen, due);
    chk(operand == x, req, operand, x);
    @(negedge clk);
    chk(done == 1'b0, "R9 pulse", {31'h0, done}, 32'h0);
    if (stray) begin
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        chk(!done && !mem_req, "R10 stray word dropped", {30'h0, done, mem_req}, 32'h0);
      end
    end
    oa_m = prep ? x : 32'h0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    ifile[0] = 32'hDEAD_BEEF;
    for (int i = 1; i < 64; i++) ifile[i] = $urandom;
    ifile[63] = 32'hFFFF_8000;
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && mem_req == 1'b0, "R11 reset outputs",
        {30'h0, done, mem_req}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0 && mem_req == 1'b0, "R11 idle after reset",
        {30'h0, done, mem_req}, 32'h0);
    // R11: OA zero without chain_start; R6 index 0 ignores port
    run_cmd(0, 0, 7'h00, 2'd0, 6'd0, 15'h0123, 0, 1, 0, "R11 R6 first word");
    // single-word forms of each mode
    run_cmd(0, 0, 7'h11, 2'd0, 6'd5,  15'h4000, 1, 1, 0, "R2 mode 0");
    run_cmd(0, 0, 7'h22, 2'd1, 6'd9,  15'h0ABC, 1, 2, 0, "R3 mode 1");
    run_cmd(0, 0, 7'h33, 2'd2, 6'd17, 15'h7FF0, 1, 3, 0, "R4 mode 2");
    run_cmd(0, 0, 7'h44, 2'd3, 6'd2,  15'h1234, 1, 4, 0, "R5 mode 3");
    // R6: top index select, address wraps past 2^15
    run_cmd(0, 0, 7'h7F, 2'd2, 6'd63, 15'h7FFF, 1, 1, 0, "R6 R4 index 63 wrap");
    // R8: a three-word preparation chain then a plain word
    run_cmd(1, 0, 7'h01, 2'd0, 6'd3, 15'h0100, 1, 1, 0, "R8 prep word 1");
    run_cmd(1, 0, 7'h02, 2'd1, 6'd4, 15'h0200, 0, 2, 0, "R8 prep word 2");
    run_cmd(1, 0, 7'h03, 2'd2, 6'd0, 15'h0300, 0, 1, 0, "R8 prep word 3");
    run_cmd(0, 0, 7'h04, 2'd3, 6'd7, 15'h0400, 0, 2, 0, "R8 R5 chain end");
    run_cmd(0, 0, 7'h05, 2'd0, 6'd0, 15'h0007, 0, 1, 0, "R8 OA cleared");
    // R7: chain_start overrides a pending OA
    run_cmd(1, 0, 7'h06, 2'd0, 6'd8, 15'h0055, 1, 1, 0, "R7 setup");
    run_cmd(0, 0, 7'h07, 2'd0, 6'd0, 15'h0066, 1, 1, 0, "R7 chain start");
    // R1: spare flag and opcode must not act as preparation
    run_cmd(0, 1, 7'h7F, 2'd0, 6'd1, 15'h0010, 1, 1, 0, "R1 spare flag");
    run_cmd(0, 0, 7'h00, 2'd0, 6'd0, 15'h0020, 0, 1, 0, "R1 OA still zero");
    // R10: stray words while busy
    run_cmd(1, 0, 7'h08, 2'd1, 6'd6, 15'h0999, 1, 3, 1, "R10 R3 stray busy");
    run_cmd(0, 0, 7'h09, 2'd0, 6'd0, 15'h0001, 0, 1, 1, "R10 R2 stray short");
    // random mix
    for (int i = 0; i < 60; i++) begin
      logic [1:0] m;
      m = 2'($urandom % 4);
      run_cmd(1'($urandom % 2), 1'($urandom % 2), 7'($urandom), m,
              6'($urandom), 15'($urandom), ($urandom % 4) == 0,
              1 + int'($urandom % 4), 0,
              (m == 2'd0) ? "R2 random" : (m == 2'd1) ? "R3 random" :
              (m == 2'd2) ? "R4 random" : "R5 random");
    end
    finish_run();
  end
endmodule